// File: doc/BRIEF.md
# Zero Length Encoding Suppressor

This block reduces one channel of digitised samples before they reach an event buffer. Each incoming sample is compared with a programmable threshold. Samples that lie beyond the threshold count as interesting. A margin of earlier samples (look-back) and a margin of later samples (look-forward) around them are also retained. Every other sample is discarded. A discarded stretch leaves a single skip word that holds the number of samples removed. A retained stretch is sent as a good word that holds its length, followed directly by the samples. Margins that touch or overlap combine into one retained stretch. A size word holding the encoded length of the event closes each event.

Samples enter with a valid strobe. An end-of-event strobe comes with the last sample of the event, or comes alone for an empty event. The look-back margin is produced by a delay line. After the end strobe, the block spends look-back steps flushing that line and then closes the event. The output is a 32-bit word stream with a valid flag. Bits [31:30] of each word give its kind: 00 sample, 01 skip, 10 good, 11 size. Bits [29:0] carry the payload.

Top module: `zle_suppressor`

## Requirements
- R1: A sample is interesting when it is strictly greater than `thr` while `pol_neg` is 0, or strictly less than `thr` while `pol_neg` is 1. A sample equal to `thr` is never interesting.
- R2: The `lbk_n` samples that come before an interesting sample in the same event are retained. Values above LBK_MAX are treated as LBK_MAX.
- R3: The `lfwd_n` samples that come after an interesting sample in the same event are retained.
- R4: A maximal stretch of discarded samples produces a skip word: bits [31:30] = 01 and bits [29:0] = the number of samples dropped.
- R5: A retained stretch produces a good word (bits [31:30] = 10, bits [29:0] = count N), followed on the very next output cycles by N sample words. Each sample word has bits [31:30] = 00, the sample in bits [13:0], and zeros elsewhere.
- R6: When the margins of several interesting samples overlap or touch, they form one retained stretch with a single good word.
- R7: A skip or good stretch longer than MAX_RUN is split into stretches of MAX_RUN samples of the same kind, plus a shorter remainder.
- R8: The last word of every event is a size word (bits [31:30] = 11). Its payload is the number of words in the event's encoded stream, counting the size word itself. An empty event gives only the size word, with value 1.
- R9: While reset is asserted, and afterwards until an event produces words, `out_valid` is 0.
- R10: Events are encoded independently. Margins never reach across an end-of-event boundary.
- R11: No word is lost or reordered, provided two conditions hold. Sample valids come on no more than every other cycle. After each end strobe the input stays idle for `lbk_n`+2 cycles, with settings held until the event's words have left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SW | Sample value |
| evt_end | input | 1 | Marks the last sample of an event (or an empty event) |
| thr | input | SW | Threshold |
| pol_neg | input | 1 | 0: keep above threshold, 1: keep below |
| lbk_n | input | clog2(LBK_MAX+1) | Look-back margin in samples |
| lfwd_n | input | LFWD_W | Look-forward margin in samples |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 32 | Encoded word: kind in [31:30], payload in [29:0] |

## Verification
Directed events cover a flat trace sitting exactly at the threshold, which tells a strict comparison apart from an inclusive one. A lone pulse is tried under each margin setting, which separates look-back from look-forward. Two nearby pulses show whether margins merge. Long flat and long pulsed traces show the split at the run limit. An empty event and back-to-back events show the size word and event isolation. Seeded random events mix polarity, margins, thresholds and pulse density, and catch ordering and counting slips in mixed patterns of stretches.

// File: rtl/zle_pkg.sv
package zle_pkg;
  localparam int WORD_W = 32;
  localparam int KIND_W = 2;
  localparam int PAY_W  = WORD_W - KIND_W;

  typedef enum logic [KIND_W-1:0] {
    K_SAMPLE = 2'b00,
    K_SKIP   = 2'b01,
    K_GOOD   = 2'b10,
    K_SIZE   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    PH_RUN,
    PH_DRAIN,
    PH_CLOSE,
    PH_SIZE
  } phase_e;
endpackage

// File: rtl/zle_fifo.sv
module zle_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         full;

  always_comb begin
    wp_d = push ? wp_q + (AW+1)'(1) : wp_q;
    rp_d = pop  ? rp_q + (AW+1)'(1) : rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[AW-1:0]] <= wdata;
  end

  assign rdata = mem[rp_q[AW-1:0]];
  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);

  // R11: pacing keeps the queues inside their depth
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/zle_window.sv
module zle_window
  import zle_pkg::*;
#(
  parameter int SW      = 14,
  parameter int LBK_MAX = 32,
  parameter int LFWD_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_valid,
  input  logic [SW-1:0]                smp_data,
  input  logic                         evt_end,
  input  logic [SW-1:0]                thr,
  input  logic                         pol_neg,
  input  logic [$clog2(LBK_MAX+1)-1:0] lbk_n,
  input  logic [LFWD_W-1:0]            lfwd_n,
  output logic                         ex_valid,
  output logic [SW-1:0]                ex_data,
  output logic                         ex_keep,
  output logic                         close_evt,
  output logic                         size_evt
);
  localparam int LBK_W = $clog2(LBK_MAX+1);
  localparam int GAP_W = ((LFWD_W > LBK_W) ? LFWD_W : LBK_W) + 1;
  localparam logic [GAP_W-1:0] GAP_SAT = '1;

  logic [SW-1:0]      dly_q [LBK_MAX];
  logic [LBK_MAX-1:0] dly_v_q;
  logic [SW-1:0]      tap_d [LBK_MAX+1];
  logic [LBK_MAX:0]   tap_v;
  phase_e             ph_q, ph_d;
  logic [LBK_W-1:0]   drn_q, drn_d, lbk_eff;
  logic [GAP_W-1:0]   gap_q, gap_d, limit;
  logic               in_v, step, over;

  assign lbk_eff = (lbk_n > LBK_W'(LBK_MAX)) ? LBK_W'(LBK_MAX) : lbk_n;
  assign in_v    = (ph_q == PH_RUN) && smp_valid;
  assign step    = in_v || (ph_q == PH_DRAIN);
  assign over    = in_v && (pol_neg ? (smp_data < thr) : (smp_data > thr));
  assign limit   = GAP_W'(lbk_eff) + GAP_W'(lfwd_n);

  assign tap_d[0] = smp_data;
  assign tap_v[0] = in_v;
  for (genvar i = 1; i <= LBK_MAX; i++) begin : g_tap
    assign tap_d[i] = dly_q[i-1];
    assign tap_v[i] = dly_v_q[i-1];
  end

  always_comb begin
    if (over)                 gap_d = '0;
    else if (gap_q == GAP_SAT) gap_d = GAP_SAT;
    else                      gap_d = gap_q + GAP_W'(1);
  end

  assign ex_valid  = step && tap_v[lbk_eff];
  assign ex_data   = tap_d[lbk_eff];
  assign ex_keep   = (gap_d <= limit);
  assign close_evt = (ph_q == PH_CLOSE);
  assign size_evt  = (ph_q == PH_SIZE);

  always_comb begin
    ph_d  = ph_q;
    drn_d = drn_q;
    case (ph_q)
      PH_RUN: begin
        if (evt_end) begin
          if (lbk_eff == '0) ph_d = PH_CLOSE;
          else begin
            ph_d  = PH_DRAIN;
            drn_d = lbk_eff;
          end
        end
      end
      PH_DRAIN: begin
        drn_d = drn_q - LBK_W'(1);
        if (drn_q == LBK_W'(1)) ph_d = PH_CLOSE;
      end
      PH_CLOSE: ph_d = PH_SIZE;
      default:  ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_RUN;
      drn_q   <= '0;
      gap_q   <= GAP_SAT;
      dly_v_q <= '0;
    end else begin
      ph_q  <= ph_d;
      drn_q <= drn_d;
      if (ph_q == PH_SIZE) begin
        gap_q   <= GAP_SAT;
        dly_v_q <= '0;
      end else if (step) begin
        gap_q   <= gap_d;
        dly_v_q <= (dly_v_q << 1) | LBK_MAX'(in_v);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      dly_q[0] <= smp_data;
      for (int i = 1; i < LBK_MAX; i++) dly_q[i] <= dly_q[i-1];
    end
  end

  // R10: no sample leaves the window while an event is being closed
  a_r10_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt || size_evt) |-> !ex_valid);
endmodule

// File: rtl/zle_runs.sv
module zle_runs
  import zle_pkg::*;
#(
  parameter int SW      = 14,
  parameter int MAX_RUN = 16,
  parameter int SIZE_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ex_valid,
  input  logic [SW-1:0]            ex_data,
  input  logic                     ex_keep,
  input  logic                     close_evt,
  input  logic                     size_evt,
  output logic                     smp_push,
  output logic [SW-1:0]            smp_wdata,
  output logic                     tok_push,
  output logic [KIND_W+SIZE_W-1:0] tok_wdata
);
  localparam int CW = $clog2(MAX_RUN+1);

  logic              good_q, good_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [SIZE_W-1:0] len_q, len_d, tok_cnt;
  kind_e             tok_kind, run_kind;

  assign run_kind  = good_q ? K_GOOD : K_SKIP;
  assign smp_push  = ex_valid && ex_keep;
  assign smp_wdata = ex_data;
  assign tok_wdata = {tok_kind, tok_cnt};

  always_comb begin
    good_d   = good_q;
    cnt_d    = cnt_q;
    tok_push = 1'b0;
    tok_kind = run_kind;
    tok_cnt  = SIZE_W'(cnt_q);
    if (ex_valid) begin
      if (cnt_q != '0 && ex_keep == good_q && cnt_q != CW'(MAX_RUN)) begin
        cnt_d = cnt_q + CW'(1);
      end else begin
        tok_push = (cnt_q != '0);
        good_d   = ex_keep;
        cnt_d    = CW'(1);
      end
    end else if (close_evt) begin
      tok_push = (cnt_q != '0);
      cnt_d    = '0;
    end else if (size_evt) begin
      tok_push = 1'b1;
      tok_kind = K_SIZE;
      tok_cnt  = len_q + SIZE_W'(1);
    end
    len_d = size_evt ? '0 : len_q + SIZE_W'(smp_push) + SIZE_W'(tok_push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else begin
      good_q <= good_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end

  // R7: a closed stretch never holds more than the run limit
  a_r7_token_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_push && tok_kind != K_SIZE) |-> (tok_cnt != '0 && tok_cnt <= SIZE_W'(MAX_RUN)));
endmodule

// File: rtl/zle_emit.sv
module zle_emit
  import zle_pkg::*;
#(
  parameter int SW      = 14,
  parameter int MAX_RUN = 16,
  parameter int SIZE_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tok_empty,
  input  logic [KIND_W+SIZE_W-1:0] tok_rdata,
  input  logic                     smp_empty,
  input  logic [SW-1:0]            smp_rdata,
  output logic                     tok_pop,
  output logic                     smp_pop,
  output logic                     out_valid,
  output logic [WORD_W-1:0]        out_word
);
  localparam int CW = $clog2(MAX_RUN+1);

  logic [CW-1:0]     left_q, left_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  kind_e             tok_kind, out_kind;
  logic [SIZE_W-1:0] tok_cnt;

  assign tok_kind = kind_e'(tok_rdata[KIND_W+SIZE_W-1:SIZE_W]);
  assign tok_cnt  = tok_rdata[SIZE_W-1:0];
  assign out_kind = kind_e'(word_q[WORD_W-1:PAY_W]);

  always_comb begin
    left_d  = left_q;
    vld_d   = 1'b0;
    word_d  = word_q;
    tok_pop = 1'b0;
    smp_pop = 1'b0;
    if (left_q != '0) begin
      smp_pop = 1'b1;
      vld_d   = 1'b1;
      word_d  = {K_SAMPLE, PAY_W'(smp_rdata)};
      left_d  = left_q - CW'(1);
    end else if (!tok_empty) begin
      tok_pop = 1'b1;
      vld_d   = 1'b1;
      word_d  = {tok_kind, PAY_W'(tok_cnt)};
      if (tok_kind == K_GOOD) left_d = CW'(tok_cnt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      left_q <= left_d;
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;

  // R5: a good word is followed at once by sample words
  a_r5_good_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && out_kind == K_GOOD) |=> (vld_q && out_kind == K_SAMPLE));
  // R4: skip counts are non-zero and bounded
  a_r4_skip_range: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && out_kind == K_SKIP) |->
      (word_q[PAY_W-1:0] != '0 && word_q[PAY_W-1:0] <= PAY_W'(MAX_RUN)));
  // R7: good counts are non-zero and bounded
  a_r7_good_range: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && out_kind == K_GOOD) |->
      (word_q[PAY_W-1:0] != '0 && word_q[PAY_W-1:0] <= PAY_W'(MAX_RUN)));
  // R11: samples of an announced stretch are already queued
  a_r11_data_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0) |-> !smp_empty);
endmodule

// File: rtl/zle_suppressor.sv
module zle_suppressor
  import zle_pkg::*;
#(
  parameter int SW        = 14,
  parameter int LBK_MAX   = 32,
  parameter int LFWD_W    = 8,
  parameter int MAX_RUN   = 16,
  parameter int SIZE_W    = 20,
  parameter int SMP_DEPTH = 64,
  parameter int TOK_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_valid,
  input  logic [SW-1:0]                smp_data,
  input  logic                         evt_end,
  input  logic [SW-1:0]                thr,
  input  logic                         pol_neg,
  input  logic [$clog2(LBK_MAX+1)-1:0] lbk_n,
  input  logic [LFWD_W-1:0]            lfwd_n,
  output logic                         out_valid,
  output logic [WORD_W-1:0]            out_word
);
  localparam int TOK_W = KIND_W + SIZE_W;

  logic [1:0]       rs_q;
  logic             rst_q;
  logic             ex_valid, ex_keep, close_evt, size_evt;
  logic [SW-1:0]    ex_data, smp_wdata, smp_rdata;
  logic             smp_push, smp_pop, smp_empty;
  logic             tok_push, tok_pop, tok_empty;
  logic [TOK_W-1:0] tok_wdata, tok_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  zle_window #(.SW(SW), .LBK_MAX(LBK_MAX), .LFWD_W(LFWD_W)) u_win (
    .clk(clk), .rst_n(rst_q), .smp_valid(smp_valid), .smp_data(smp_data),
    .evt_end(evt_end), .thr(thr), .pol_neg(pol_neg), .lbk_n(lbk_n),
    .lfwd_n(lfwd_n), .ex_valid(ex_valid), .ex_data(ex_data),
    .ex_keep(ex_keep), .close_evt(close_evt), .size_evt(size_evt));

  zle_runs #(.SW(SW), .MAX_RUN(MAX_RUN), .SIZE_W(SIZE_W)) u_runs (
    .clk(clk), .rst_n(rst_q), .ex_valid(ex_valid), .ex_data(ex_data),
    .ex_keep(ex_keep), .close_evt(close_evt), .size_evt(size_evt),
    .smp_push(smp_push), .smp_wdata(smp_wdata),
    .tok_push(tok_push), .tok_wdata(tok_wdata));

  zle_fifo #(.W(SW), .DEPTH(SMP_DEPTH)) u_smp_q (
    .clk(clk), .rst_n(rst_q), .push(smp_push), .wdata(smp_wdata),
    .pop(smp_pop), .rdata(smp_rdata), .empty(smp_empty));

  zle_fifo #(.W(TOK_W), .DEPTH(TOK_DEPTH)) u_tok_q (
    .clk(clk), .rst_n(rst_q), .push(tok_push), .wdata(tok_wdata),
    .pop(tok_pop), .rdata(tok_rdata), .empty(tok_empty));

  zle_emit #(.SW(SW), .MAX_RUN(MAX_RUN), .SIZE_W(SIZE_W)) u_emit (
    .clk(clk), .rst_n(rst_q), .tok_empty(tok_empty), .tok_rdata(tok_rdata),
    .smp_empty(smp_empty), .smp_rdata(smp_rdata), .tok_pop(tok_pop),
    .smp_pop(smp_pop), .out_valid(out_valid), .out_word(out_word));

  // R9: nothing leaves the block while reset is held
  a_r9_quiet_in_reset: assert property (@(posedge clk)
    !rst_q |-> !out_valid);
endmodule

// File: tb/zle_suppressor_tb_top.sv
`timescale 1ns/1ps
module zle_suppressor_tb_top;
  localparam int SW = 14, LBK_MAX = 32, LFWD_W = 8, MAX_RUN = 16;
  localparam int LBK_W = $clog2(LBK_MAX+1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, smp_valid, evt_end, pol_neg, out_valid;
  logic [SW-1:0]     smp_data, thr;
  logic [LBK_W-1:0]  lbk_n;
  logic [LFWD_W-1:0] lfwd_n;
  logic [31:0]       out_word;

  zle_suppressor #(.SW(SW), .LBK_MAX(LBK_MAX), .LFWD_W(LFWD_W), .MAX_RUN(MAX_RUN),
    .SIZE_W(20), .SMP_DEPTH(64), .TOK_DEPTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .evt_end(evt_end), .thr(thr), .pol_neg(pol_neg), .lbk_n(lbk_n),
    .lfwd_n(lfwd_n), .out_valid(out_valid), .out_word(out_word));

  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [31:0] got_q[$], exp_q[$];
  logic [13:0] ev[$];

  always @(negedge clk) if (rst_n && out_valid) got_q.push_back(out_word);

  function automatic bit is_over(logic [13:0] s, logic [13:0] t, bit neg);
    return neg ? (s < t) : (s > t);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic build_exp(int lbk, int lfwd, logic [13:0] t, bit neg);
    int n, i, e, p, c;
    bit keep[$];
    bit k;
    n = ev.size();
    exp_q.delete();
    for (int a = 0; a < n; a++) begin
      k = 1'b0;
      for (int j = a - lfwd; j <= a + lbk; j++)
        if (j >= 0 && j < n && is_over(ev[j], t, neg)) k = 1'b1;
      keep.push_back(k);
    end
    i = 0;
    while (i < n) begin
      k = keep[i];
      e = i;
      while (e < n && keep[e] == k) e++;
      p = i;
      while (p < e) begin
        c = (e - p > MAX_RUN) ? MAX_RUN : e - p;
        if (k) begin
          exp_q.push_back({2'b10, 30'(c)});
          for (int q = p; q < p + c; q++) exp_q.push_back({18'b0, ev[q]});
        end else exp_q.push_back({2'b01, 30'(c)});
        p += c;
      end
      i = e;
    end
    exp_q.push_back({2'b11, 30'(exp_q.size() + 1)});
  endtask

  task automatic run_event(string tag, int lbk, int lfwd, logic [13:0] t, bit neg, int gapmax);
    int n, bad;
    n = ev.size();
    got_q.delete();
    @(negedge clk);
    thr = t; pol_neg = neg; lbk_n = LBK_W'(lbk); lfwd_n = LFWD_W'(lfwd);
    if (n == 0) begin
      @(negedge clk) evt_end = 1'b1;
      @(negedge clk) evt_end = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        smp_valid = 1'b1; smp_data = ev[i]; evt_end = (i == n - 1);
        @(negedge clk);
        smp_valid = 1'b0; evt_end = 1'b0;
        repeat ($urandom_range(gapmax)) @(negedge clk);
      end
    end
    repeat (lbk + 4) @(negedge clk);
    repeat (2 * n + 60) @(negedge clk);
    build_exp(lbk, lfwd, t, neg);
    bad = -1;
    for (int i = 0; i < exp_q.size(); i++)
      if (bad < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) bad = i;
    if (bad < 0 && got_q.size() != exp_q.size()) bad = exp_q.size();
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: word %0d got %h expected %h (words got %0d expected %0d)", tag, bad,
        (bad < got_q.size()) ? got_q[bad] : 32'hx, (bad < exp_q.size()) ? exp_q[bad] : 32'hx,
        got_q.size(), exp_q.size());
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, r, ok;
    void'($urandom(32'd4711));
    rst_n = 1'b0; smp_valid = 1'b0; evt_end = 1'b0; smp_data = '0;
    thr = '0; pol_neg = 1'b0; lbk_n = '0; lfwd_n = '0;
    ok = 1;
    repeat (4) @(negedge clk) if (out_valid !== 1'b0) ok = 0;
    rst_n = 1'b1;
    repeat (8) @(negedge clk) if (out_valid !== 1'b0) ok = 0;
    check(ok == 1, "R9 idle after reset", {31'b0, out_valid}, 32'h0);

    // R1: samples equal to the threshold are dropped
    ev.delete(); repeat (5) ev.push_back(14'd500);
    run_event("R1 equal to threshold", 0, 0, 14'd500, 1'b0, 1);
    check(got_q.size() > 0 && got_q[0] == {2'b01, 30'd5}, "R4 skip count of flat trace",
      (got_q.size() > 0) ? got_q[0] : 32'hx, {2'b01, 30'd5});
    // R1: negative logic
    ev.delete(); ev = '{600, 600, 400, 600, 399, 600};
    run_event("R1 negative polarity", 0, 0, 14'd500, 1'b1, 1);
    // R2: look-back only
    ev.delete(); ev = '{10, 10, 10, 10, 10, 90, 10, 10, 10, 10};
    run_event("R2 look-back margin", 3, 0, 14'd50, 1'b0, 1);
    check(got_q.size() > 0 && got_q[0] == {2'b01, 30'd2}, "R2 skip ahead of margin",
      (got_q.size() > 0) ? got_q[0] : 32'hx, {2'b01, 30'd2});
    // R3: look-forward only
    run_event("R3 look-forward margin", 0, 2, 14'd50, 1'b0, 1);
    // R6: two pulses with overlapping margins
    ev.delete(); repeat (16) ev.push_back(14'd10); ev[5] = 14'd90; ev[9] = 14'd90;
    run_event("R6 merged margins", 2, 2, 14'd50, 1'b0, 1);
    check(got_q.size() > 1 && got_q[1] == {2'b10, 30'd9}, "R6 single good word",
      (got_q.size() > 1) ? got_q[1] : 32'hx, {2'b10, 30'd9});
    // R7: long interesting stretch
    ev.delete(); repeat (40) ev.push_back(14'd900);
    run_event("R7 long good split", 0, 0, 14'd50, 1'b0, 1);
    check(got_q.size() == 44 && got_q[43] == {2'b11, 30'd44}, "R8 size of split event",
      (got_q.size() > 0) ? got_q[got_q.size()-1] : 32'hx, {2'b11, 30'd44});
    // R7: long dropped stretch
    ev.delete(); repeat (40) ev.push_back(14'd5);
    run_event("R7 long skip split", 4, 4, 14'd50, 1'b0, 1);
    // R8: empty event
    ev.delete();
    run_event("R8 empty event", 3, 3, 14'd50, 1'b0, 1);
    check(got_q.size() == 1 && got_q[0] == {2'b11, 30'd1}, "R8 empty size word",
      (got_q.size() > 0) ? got_q[0] : 32'hx, {2'b11, 30'd1});
    // R10: margins stop at the event edge
    ev.delete(); ev = '{10, 10, 10, 10, 95};
    run_event("R10 event ends on pulse", 6, 6, 14'd50, 1'b0, 0);
    ev.delete(); ev = '{10, 10, 10, 10, 10, 10};
    run_event("R10 next event flat", 6, 6, 14'd50, 1'b0, 0);
    check(got_q.size() == 2 && got_q[0] == {2'b01, 30'd6}, "R10 no carried margin",
      (got_q.size() > 0) ? got_q[0] : 32'hx, {2'b01, 30'd6});

    // R2 R3 R6 R11: seeded random events
    for (int e = 0; e < 30; e++) begin
      logic [13:0] t;
      t = 14'($urandom_range(14000, 2000));
      n = $urandom_range(60, 1);
      ev.delete();
      for (int i = 0; i < n; i++) begin
        r = $urandom_range(99);
        if (r < 12)      ev.push_back(t + 14'($urandom_range(400, 1)));
        else if (r < 24) ev.push_back(t - 14'($urandom_range(400, 1)));
        else             ev.push_back(t + 14'($urandom_range(4)) - 14'd2);
      end
      run_event("R11 random stream", $urandom_range(LBK_MAX), $urandom_range(20),
        t, 1'($urandom_range(1)), 2);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule